// File: doc/BRIEF.md
# Multi-width operand address sequencer

The sequencer produces the run of addresses needed to stream one operand into or out of a processing element's local memory or register file. Both memories are addressed in 32-bit units. An access moves 32, 64 or 128 bits. Every width starts from the same 32-bit-unit address. The step between elements equals the width in 32-bit units, so consecutive elements tile the memory without overlap.

A request is launched with a one-cycle start strobe. The strobe carries the start address, a width code, an element count, a memory-kind select and a side bit that picks one of the two memory halves. The start address, width, count and side are captured when the strobe is accepted.

Before any address is issued, the request is checked. A misaligned wide start is refused. So is a run whose last element would fall beyond the selected memory. While a run is active, the caller steps it forward one element per cycle by raising an advance enable. A one-cycle done pulse follows the final element.

Top module: `opnd_addr_seq`

## Requirements
- R1: After reset, valid_o, done_o, align_err_o and range_err_o are all low.
- R2: For an accepted, error-free request with a nonzero count, valid_o rises in the cycle after the start strobe, and addr_o then equals the start address, for every width code.
- R3: Width codes are 2'b00 for 32 bits, 2'b01 for 64 bits and 2'b10 for 128 bits. Each accepted advance moves addr_o forward by 1, 2 or 4 respectively.
- R4: While a run is active and adv_i is low, addr_o, side_o and valid_o keep their values.
- R5: The cycle after adv_i is accepted on the last element, done_o is high and valid_o is low. In the cycle after that, done_o is low again.
- R6: align_err_o is set in the cycle after an accepted start in three cases: width 2'b01 with an odd start address, width 2'b10 with a start address that is not a multiple of 4, or width code 2'b11. The flag stays set until the next accepted start. While it is set, no address is issued and done_o does not pulse.
- R7: range_err_o is set in the cycle after an accepted start when start + count × stride exceeds the memory size. The size is 4096 units for the local memory (mem_sel_i = 0) and 512 units for the register file (mem_sel_i = 1). The flag stays set until the next accepted start. While it is set, no address is issued and done_o does not pulse.
- R8: An error-free request with a count of zero issues no address, and pulses done_o in the cycle after the start.
- R9: side_o equals the side bit captured at start, and stays constant for the whole run.
- R10: A start strobe that arrives while a run is active is ignored. The run continues with its own address, count and side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted only when no run is active |
| base_i | input | 12 | Start address in 32-bit units |
| width_i | input | 2 | Access width code |
| count_i | input | 13 | Number of elements |
| mem_sel_i | input | 1 | 0 = local memory, 1 = register file |
| side_i | input | 1 | Memory half select, carried with the addresses |
| adv_i | input | 1 | Step to the next element |
| addr_o | output | 12 | Current address in 32-bit units |
| side_o | output | 1 | Side bit of the current run |
| valid_o | output | 1 | Address is being issued |
| done_o | output | 1 | One-cycle pulse after the final element |
| align_err_o | output | 1 | Last accepted request was misaligned |
| range_err_o | output | 1 | Last accepted request ran past the memory end |

## Verification
Two events can fall on the same clock edge: a fresh start strobe, and the advance that retires the final element of the running sequence. The bench provokes this by raising start_i with a different address on randomly chosen active cycles, including the last one. It judges the result by checking three things: the done pulse still follows on schedule, no new run begins from the ignored strobe, and the next real request starts at its own address. The alignment and range checks can also both fire on one request. Directed cases near the ends of both memories, together with random misaligned starts, show each flag on its own and both together.

// File: rtl/opnd_seq_pkg.sv
package opnd_seq_pkg;

    localparam int LM_LW_WORDS = 2048;
    localparam int RF_LW_WORDS = 256;
    localparam int UNITS_PER_LW = 2;
    localparam int LM_UNITS = LM_LW_WORDS * UNITS_PER_LW;
    localparam int RF_UNITS = RF_LW_WORDS * UNITS_PER_LW;
    localparam int SEQ_ADDR_W = $clog2(LM_UNITS);
    localparam int SEQ_CNT_W = SEQ_ADDR_W + 1;
    localparam int STRIDE_W = 3;

    typedef enum logic [1:0] {
        OW_32  = 2'b00,
        OW_64  = 2'b01,
        OW_128 = 2'b10,
        OW_BAD = 2'b11
    } op_width_e;

    typedef enum logic {
        MEM_LOCAL = 1'b0,
        MEM_REGF  = 1'b1
    } mem_kind_e;

    typedef struct packed {
        logic align;
        logic range;
    } seq_err_t;

    function automatic logic [STRIDE_W-1:0] stride_of(op_width_e w);
        case (w)
            OW_32:   return 3'd1;
            OW_64:   return 3'd2;
            OW_128:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic misaligned(op_width_e w, logic [1:0] lo);
        case (w)
            OW_32:   return 1'b0;
            OW_64:   return lo[0];
            OW_128:  return |lo;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/seq_check.sv
module seq_check
    import opnd_seq_pkg::*;
#(
    parameter int ADDR_W  = SEQ_ADDR_W,
    parameter int CNT_W   = SEQ_CNT_W,
    parameter int LM_SIZE = LM_UNITS,
    parameter int RF_SIZE = RF_UNITS
) (
    input  logic [ADDR_W-1:0]   base_i,
    input  op_width_e           width_i,
    input  logic [CNT_W-1:0]    count_i,
    input  mem_kind_e           kind_i,
    output logic [STRIDE_W-1:0] stride_o,
    output seq_err_t            err_o
);

    localparam int SUM_W = ADDR_W + CNT_W + STRIDE_W + 1;

    logic [SUM_W-1:0] end_unit;
    logic [SUM_W-1:0] limit;

    always_comb begin
        stride_o  = stride_of(width_i);
        end_unit  = SUM_W'(base_i) + SUM_W'(count_i) * SUM_W'(stride_o);
        limit     = (kind_i == MEM_REGF) ? SUM_W'(RF_SIZE) : SUM_W'(LM_SIZE);
        err_o.align = misaligned(width_i, base_i[1:0]);
        err_o.range = end_unit > limit;
    end

    always_comb begin
        if (!err_o.align) begin
            p_aligned_stride_r6: assert (stride_o != '0);
        end
    end

endmodule

// File: rtl/seq_walker.sv
module seq_walker
    import opnd_seq_pkg::*;
#(
    parameter int ADDR_W = SEQ_ADDR_W,
    parameter int CNT_W  = SEQ_CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                launch_i,
    input  logic                empty_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic                side_i,
    input  logic                adv_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                side_o,
    output logic                active_o,
    output logic                done_o
);

    logic                active_q;
    logic                done_q;
    logic                side_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [CNT_W-1:0]    rem_q;
    logic [STRIDE_W-1:0] stride_q;
    logic                last_elem;

    assign last_elem = (rem_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            side_q   <= 1'b0;
            addr_q   <= '0;
            rem_q    <= '0;
            stride_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (launch_i) begin
                    active_q <= 1'b1;
                    addr_q   <= base_i;
                    rem_q    <= count_i;
                    stride_q <= stride_i;
                    side_q   <= side_i;
                end else if (empty_i) begin
                    done_q <= 1'b1;
                end
            end else if (adv_i) begin
                if (last_elem) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    addr_q <= addr_q + ADDR_W'(stride_q);
                    rem_q  <= rem_q - CNT_W'(1);
                end
            end
        end
    end

    assign addr_o   = addr_q;
    assign side_o   = side_q;
    assign active_o = active_q;
    assign done_o   = done_q;

    p_first_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (launch_i && !active_q) |=> (active_q && addr_q == $past(base_i)));

    p_stride_step_r3: assert property (@(posedge clk) disable iff (rst)
        (active_q && adv_i && !last_elem) |=> (addr_q == $past(addr_q) + ADDR_W'($past(stride_q))));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (active_q && !adv_i) |=> (active_q && $stable(addr_q) && $stable(side_q)));

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_done_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        (active_q && adv_i && last_elem) |=> (done_q && !active_q));

    p_side_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (active_q && !(adv_i && last_elem)) |=> $stable(side_q));

endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
    import opnd_seq_pkg::*;
#(
    parameter int ADDR_W  = SEQ_ADDR_W,
    parameter int CNT_W   = SEQ_CNT_W,
    parameter int LM_SIZE = LM_UNITS,
    parameter int RF_SIZE = RF_UNITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        width_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              mem_sel_i,
    input  logic              side_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              side_o,
    output logic              valid_o,
    output logic              done_o,
    output logic              align_err_o,
    output logic              range_err_o
);

    logic [STRIDE_W-1:0] stride;
    seq_err_t            req_err;
    seq_err_t            err_q;
    logic                busy;
    logic                accept;
    logic                req_bad;
    logic                launch;
    logic                empty;

    seq_check #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .LM_SIZE(LM_SIZE),
        .RF_SIZE(RF_SIZE)
    ) i_check (
        .base_i  (base_i),
        .width_i (op_width_e'(width_i)),
        .count_i (count_i),
        .kind_i  (mem_kind_e'(mem_sel_i)),
        .stride_o(stride),
        .err_o   (req_err)
    );

    assign accept  = start_i && !busy;
    assign req_bad = req_err.align || req_err.range;
    assign launch  = accept && !req_bad && (count_i != '0);
    assign empty   = accept && !req_bad && (count_i == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (accept) begin
            err_q <= req_err;
        end
    end

    seq_walker #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) i_walker (
        .clk     (clk),
        .rst     (rst),
        .launch_i(launch),
        .empty_i (empty),
        .base_i  (base_i),
        .stride_i(stride),
        .count_i (count_i),
        .side_i  (side_i),
        .adv_i   (adv_i),
        .addr_o  (addr_o),
        .side_o  (side_o),
        .active_o(busy),
        .done_o  (done_o)
    );

    assign valid_o     = busy;
    assign align_err_o = err_q.align;
    assign range_err_o = err_q.range;

    p_align_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        align_err_o |-> (!valid_o && !done_o));

    p_range_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        range_err_o |-> (!valid_o && !done_o));

    p_done_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !valid_o);

    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (valid_o && start_i && !adv_i) |=> (valid_o && $stable(addr_o)));

    p_err_held_r6: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(align_err_o) && $stable(range_err_o)));

endmodule

// File: tb/test_opnd_addr_seq.sv
`timescale 1ns/1ps
module test_opnd_addr_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [11:0] base_i;
    logic [1:0]  width_i;
    logic [12:0] count_i;
    logic        mem_sel_i;
    logic        side_i;
    logic        adv_i;
    logic [11:0] addr_o;
    logic        side_o;
    logic        valid_o;
    logic        done_o;
    logic        align_err_o;
    logic        range_err_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    opnd_addr_seq i_opnd_addr_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .base_i     (base_i),
        .width_i    (width_i),
        .count_i    (count_i),
        .mem_sel_i  (mem_sel_i),
        .side_i     (side_i),
        .adv_i      (adv_i),
        .addr_o     (addr_o),
        .side_o     (side_o),
        .valid_o    (valid_o),
        .done_o     (done_o),
        .align_err_o(align_err_o),
        .range_err_o(range_err_o)
    );

    function automatic int exp_stride(logic [1:0] w);
        return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : (w == 2'b10) ? 4 : 0;
    endfunction

    function automatic bit exp_align(logic [1:0] w, int b);
        if (w == 2'b11) return 1'b1;
        if (w == 2'b01) return (b % 2) != 0;
        if (w == 2'b10) return (b % 4) != 0;
        return 1'b0;
    endfunction

    function automatic bit exp_range(logic [1:0] w, int b, int c, bit ms);
        int lim;
        lim = ms ? 512 : 4096;
        return (b + c * exp_stride(w)) > lim;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_seq(int b, logic [1:0] w, int c, bit ms, bit sd, int advpct);
        bit ea, er, a, poke;
        int ex, rem;
        base_i = 12'(b); width_i = w; count_i = 13'(c);
        mem_sel_i = ms; side_i = sd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ea = exp_align(w, b);
        er = exp_range(w, b, c, ms);
        if (ea || er) begin
            chk("R6", "align_err", align_err_o, ea);
            chk("R7", "range_err", range_err_o, er);
            chk("R6", "valid on error", valid_o, 0);
            chk("R7", "done on error", done_o, 0);
            @(negedge clk);
            chk("R6", "align_err held", align_err_o, ea);
            chk("R7", "range_err held", range_err_o, er);
            chk("R7", "done after error", done_o, 0);
            return;
        end
        if (c == 0) begin
            chk("R8", "done for empty", done_o, 1);
            chk("R8", "valid for empty", valid_o, 0);
            @(negedge clk);
            chk("R8", "done drops", done_o, 0);
            return;
        end
        ex = b; rem = c;
        chk("R2", "first addr", addr_o, b);
        forever begin
            chk("R4", "valid active", valid_o, 1);
            chk("R3", "addr", addr_o, ex);
            chk("R9", "side", side_o, sd);
            chk("R6", "no align_err", align_err_o, 0);
            chk("R7", "no range_err", range_err_o, 0);
            a = ($urandom % 100) < advpct;
            poke = ($urandom % 6) == 0;
            adv_i = a;
            if (poke) begin
                start_i = 1'b1;
                base_i = 12'(b ^ 12'h155);
                side_i = ~sd;
                count_i = 13'd0;
            end
            @(negedge clk);
            start_i = 1'b0; adv_i = 1'b0;
            if (a) begin
                if (rem == 1) begin
                    chk("R5", "done after last", done_o, 1);
                    chk("R5", "valid after last", valid_o, 0);
                    @(negedge clk);
                    chk("R5", "done single", done_o, 0);
                    chk("R10", "no run from ignored start", valid_o, 0);
                    break;
                end
                ex += exp_stride(w);
                rem--;
            end else begin
                chk("R4", "hold addr", addr_o, ex);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; start_i = 1'b0; base_i = '0; width_i = '0; count_i = '0;
        mem_sel_i = 1'b0; side_i = 1'b0; adv_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid", valid_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "align_err", align_err_o, 0);
        chk("R1", "range_err", range_err_o, 0);

        run_seq(0, 2'b00, 5, 1'b0, 1'b0, 100);
        run_seq(12, 2'b00, 3, 1'b0, 1'b1, 100);
        run_seq(12, 2'b01, 3, 1'b0, 1'b0, 100);
        run_seq(12, 2'b10, 3, 1'b1, 1'b1, 100);
        run_seq(40, 2'b10, 8, 1'b0, 1'b1, 30);
        run_seq(5, 2'b01, 2, 1'b0, 1'b0, 100);
        run_seq(6, 2'b10, 2, 1'b0, 1'b0, 100);
        run_seq(8, 2'b11, 2, 1'b0, 1'b0, 100);
        run_seq(508, 2'b10, 1, 1'b1, 1'b0, 100);
        run_seq(508, 2'b10, 2, 1'b1, 1'b0, 100);
        run_seq(4092, 2'b10, 1, 1'b0, 1'b1, 100);
        run_seq(4094, 2'b01, 2, 1'b0, 1'b0, 100);
        run_seq(4095, 2'b10, 3, 1'b0, 1'b0, 100);
        run_seq(20, 2'b01, 0, 1'b1, 1'b0, 100);
        run_seq(100, 2'b00, 10, 1'b0, 1'b0, 50);

        for (int i = 0; i < 200; i++) begin
            logic [1:0] w;
            bit ms;
            int b, lim;
            w = 2'($urandom % 3);
            if (($urandom % 20) == 0) w = 2'b11;
            ms = 1'($urandom);
            lim = ms ? 512 : 4096;
            b = $urandom % lim;
            if (($urandom % 4) != 0) b = b & ~(exp_stride(w) - 1);
            run_seq(b, w, $urandom % 12, ms, 1'($urandom), 40 + $urandom % 61);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule